// File: doc/BRIEF.md
# I/O Register Space with Last-Read Latch

This block is the I/O register space of a small 8-bit controller. It holds three real registers for one port: an output register, a direction register and a synchronized copy of the input pins. Beside them sits a hidden latch that captures every value the I/O-instruction read path returns. Twelve reserved addresses have no storage of their own. Reading any of them returns the latch.

The requester reaches the space through four paths:
- an I/O-instruction read strobe;
- a write strobe;
- a data-space load strobe, which returns the same values but never touches the latch;
- a bit-operation strobe with a 2-bit command that sets, clears or tests one bit.

Set and clear are done as read-modify-write. The read phase loads the latch with the byte as it was before the change. A test also loads the latch with the whole byte and raises a skip flag.

Only one strobe is expected per cycle. If several arrive together, the priority is bit operation, then write, then I/O read, then data-space load. Read data and the skip flag are registered. The latch and the registers update at the clock edge that samples the strobe.

Top module: `ioreg_space`

## Requirements
- R1: After a synchronous active-low reset, port_out, dir_out, rdata, skip and the latch are all 0x00 or 0.
- R2: An I/O read (io_rd) of the pin (0x09), direction (0x0A) or port (0x0B) address puts that register's value on rdata one cycle later, and loads the same value into the latch.
- R3: An I/O read of any reserved address returns the latch value. The reserved addresses are 0x00, 0x01, 0x02 and 0x0C through 0x14. The read leaves the latch contents unchanged.
- R4: The latch keeps its value across any number of cycles with no I/O read and no bit operation.
- R5: A data-space load (ds_rd) returns the same value an I/O read of that address would return, one cycle later, and leaves the latch unchanged.
- R6: A write (io_wr) to 0x0B or 0x0A updates port_out or dir_out one cycle later. A write to the pin address 0x09 has no effect.
- R7: A write to a reserved address changes neither port_out, dir_out nor the latch.
- R8: Bit command 00 sets and command 01 clears bit bit_sel of the addressed register. The latch takes the value from before the change. For example, 0xF3 with bit 2 set leaves 0xF3 in the latch and 0xF7 in the port.
- R9: Bit command 10 (skip-if-set) and command 11 (skip-if-clear) read the register. One cycle later, skip equals the tested bit (command 10) or its inverse (command 11). The latch takes the full byte and the register is unchanged. skip is 0 in every cycle that does not follow a test.
- R10: A bit operation on a reserved address reads the latch and discards its write phase. The latch keeps its value, and a test takes its bit from the latch.
- R11: A change on pin_in becomes visible to reads after two clock edges of synchronization.
- R12: An address that is neither mapped nor reserved reads 0x00. An I/O read of such an address loads 0x00 into the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_rd | input | 1 | I/O-instruction read strobe |
| io_wr | input | 1 | Write strobe |
| ds_rd | input | 1 | Data-space load strobe |
| bit_op | input | 1 | Bit-operation strobe |
| bit_cmd | input | 2 | 00 set, 01 clear, 10 skip-if-set, 11 skip-if-clear |
| bit_sel | input | 3 | Bit index for bit operations |
| addr | input | 6 | I/O address |
| wdata | input | 8 | Write data |
| pin_in | input | 8 | External pin levels |
| rdata | output | 8 | Registered read data |
| skip | output | 1 | Registered skip result of a bit test |
| port_out | output | 8 | Port output register |
| dir_out | output | 8 | Direction register |

## Verification
The results of a strobe have different due times:
- rdata and skip are due on the first edge after the strobe.
- port_out and dir_out are due on the first edge after a write or a set/clear.
- The latch is also loaded on that first edge.
- A new pin level needs two further edges before a read can see it.

The bench drives each strobe for one cycle starting at a falling edge. It compares the outputs at the next falling edge, which is half a cycle after the edge that produced them. The latch has no port of its own, so the bench brings it out with a data-space load of a reserved address, which leaves the latch untouched. After changing pin_in, the bench idles three cycles before it reads the pins.

// File: rtl/ioreg_pkg.sv
// Shared types and address helpers for the I/O register space.
// Assumes a 6-bit I/O address. The reserved set is fixed by behaviour.
package ioreg_pkg;

    localparam int IO_AW = 6;

    // Bit-operation command encoding
    typedef enum logic [1:0] {
        BOP_SET  = 2'b00,
        BOP_CLR  = 2'b01,
        BOP_TSTS = 2'b10,
        BOP_TSTC = 2'b11
    } bop_e;

    // One-hot select of the real registers
    typedef struct packed {
        logic port;
        logic dir;
        logic pin;
    } sel_t;

    // True for the storage-less addresses that alias the latch
    function automatic logic addr_is_rsv(input logic [IO_AW-1:0] a);
        return (a <= 6'h02) || ((a >= 6'h0C) && (a <= 6'h14));
    endfunction

endpackage

// File: rtl/ioreg_decode.sv
// Address decoder: turns an I/O address into a register select.
// Also flags reserved addresses. Purely combinational.
module ioreg_decode
    import ioreg_pkg::*;
#(
    parameter logic [IO_AW-1:0] PORT_A = 6'h0B,
    parameter logic [IO_AW-1:0] DIR_A  = 6'h0A,
    parameter logic [IO_AW-1:0] PIN_A  = 6'h09
) (
    input  logic [IO_AW-1:0] addr,
    output sel_t             sel,
    output logic             rsv
);

    // Compare the address against each mapped register and the reserved set
    always_comb begin
        sel.port = (addr == PORT_A);
        sel.dir  = (addr == DIR_A);
        sel.pin  = (addr == PIN_A);
        rsv      = addr_is_rsv(addr);
    end

endmodule

// File: rtl/ioreg_bank.sv
// Real register bank: port output, direction and synchronized pin input.
// Assumes sel is one-hot or zero. The pin register is read-only.
module ioreg_bank
    import ioreg_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sel_t          sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] port_q,
    output logic [DW-1:0] dir_q
);

    logic [SYNC_STAGES-1:0][DW-1:0] sync_q;

    // Writable registers: port and direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            if (sel.port) port_q <= wr_data;
            if (sel.dir)  dir_q  <= wr_data;
        end
    end

    // Pin synchronizer chain, one stage per generate step
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= '0;
                else        sync_q[0] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= '0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Read multiplexer over the real registers
    always_comb begin
        rd_val = '0;
        if (sel.port)     rd_val = port_q;
        else if (sel.dir) rd_val = dir_q;
        else if (sel.pin) rd_val = sync_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/ioreg_bitalu.sv
// Bit modify/test unit for read-modify-write bit commands.
// Combinational. Assumes the caller gates the write by the command type.
module ioreg_bitalu
    import ioreg_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic [1:0]    cmd,
    input  logic [BW-1:0] bit_idx,
    input  logic [DW-1:0] old_val,
    output logic [DW-1:0] new_val,
    output logic          is_write,
    output logic          test_res
);

    logic [DW-1:0] mask;

    // Build the mask, the modified byte and the skip decision
    always_comb begin
        mask     = DW'(1) << bit_idx;
        is_write = 1'b0;
        new_val  = old_val;
        test_res = 1'b0;
        case (bop_e'(cmd))
            BOP_SET:  begin is_write = 1'b1; new_val = old_val | mask;  end
            BOP_CLR:  begin is_write = 1'b1; new_val = old_val & ~mask; end
            BOP_TSTS: test_res = old_val[bit_idx];
            BOP_TSTC: test_res = ~old_val[bit_idx];
            default:  ;
        endcase
    end

endmodule

// File: rtl/ioreg_space.sv
// Top of the I/O register space with a hidden last-read latch.
// Every I/O-instruction read, including the read phase of a bit command,
// loads the latch. Reserved addresses return it, and data-space loads
// leave it alone. Assumes at most one strobe per cycle. If several come,
// the priority is bit_op, then io_wr, then io_rd, then ds_rd.
module ioreg_space
    import ioreg_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [IO_AW-1:0] PORT_A = 6'h0B,
    parameter logic [IO_AW-1:0] DIR_A  = 6'h0A,
    parameter logic [IO_AW-1:0] PIN_A  = 6'h09,
    localparam int BW = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic             ds_rd,
    input  logic             bit_op,
    input  logic [1:0]       bit_cmd,
    input  logic [BW-1:0]    bit_sel,
    input  logic [IO_AW-1:0] addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    pin_in,
    output logic [DW-1:0]    rdata,
    output logic             skip,
    output logic [DW-1:0]    port_out,
    output logic [DW-1:0]    dir_out
);

    sel_t          sel;
    logic          rsv;
    logic [DW-1:0] bank_val, rd_mux, alu_val, latch_q;
    logic          alu_wr, alu_test;
    logic          op_bit, op_wr, op_rd, op_ds;
    logic          bank_we;
    logic [DW-1:0] bank_wd;

    ioreg_decode #(.PORT_A(PORT_A), .DIR_A(DIR_A), .PIN_A(PIN_A)) u_dec (
        .addr (addr),
        .sel  (sel),
        .rsv  (rsv)
    );

    ioreg_bank #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (bank_we),
        .wr_data (bank_wd),
        .pin_in  (pin_in),
        .rd_val  (bank_val),
        .port_q  (port_out),
        .dir_q   (dir_out)
    );

    ioreg_bitalu #(.DW(DW)) u_alu (
        .cmd      (bit_cmd),
        .bit_idx  (bit_sel),
        .old_val  (rd_mux),
        .new_val  (alu_val),
        .is_write (alu_wr),
        .test_res (alu_test)
    );

    // Arbitrate the strobes and form the read value and the bank write
    always_comb begin
        op_bit  = bit_op;
        op_wr   = io_wr & ~bit_op;
        op_rd   = io_rd & ~bit_op & ~io_wr;
        op_ds   = ds_rd & ~bit_op & ~io_wr & ~io_rd;
        rd_mux  = rsv ? latch_q : bank_val;
        bank_we = op_wr | (op_bit & alu_wr);
        bank_wd = op_bit ? alu_val : wdata;
    end

    // Latch, read-data register and skip flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            rdata   <= '0;
            skip    <= 1'b0;
        end else begin
            skip <= op_bit & bit_cmd[1] & alu_test;
            if (op_bit | op_rd) latch_q <= rd_mux;
            if (op_rd | op_ds)  rdata   <= rd_mux;
        end
    end

endmodule

// File: rtl/ioreg_space_chk.sv
// Assertion checker for ioreg_space, attached through bind.
// It observes the ports and the hidden latch.
module ioreg_space_chk
    import ioreg_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [IO_AW-1:0] PORT_A = 6'h0B,
    localparam int BW = $clog2(DW)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_rd,
    input logic             io_wr,
    input logic             ds_rd,
    input logic             bit_op,
    input logic [1:0]       bit_cmd,
    input logic [BW-1:0]    bit_sel,
    input logic [IO_AW-1:0] addr,
    input logic [DW-1:0]    rdata,
    input logic             skip,
    input logic [DW-1:0]    port_out,
    input logic [DW-1:0]    dir_out,
    input logic [DW-1:0]    latch_q
);

    logic solo_rd;
    logic solo_ds;

    // Qualify single-strobe cycles
    always_comb begin
        solo_rd = io_rd & ~bit_op & ~io_wr;
        solo_ds = ds_rd & ~bit_op & ~io_wr & ~io_rd;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) && rst_n |-> latch_q == '0 && skip == 1'b0);

    assert_read_loads_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        solo_rd |=> latch_q == rdata);

    assert_rsv_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        solo_rd && addr_is_rsv(addr) |=> $stable(latch_q));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd && !bit_op |=> $stable(latch_q));

    assert_ds_no_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        solo_ds |=> $stable(latch_q));

    assert_rsv_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && !bit_op && addr_is_rsv(addr)
        |=> $stable(port_out) && $stable(dir_out) && $stable(latch_q));

    assert_rmw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_op && bit_cmd == 2'b00 && addr == PORT_A
        |=> latch_q == $past(port_out)
            && port_out == ($past(port_out) | (DW'(1) << $past(bit_sel))));

    assert_skip_only_test_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_op && bit_cmd[1]) |=> !skip);

endmodule

bind ioreg_space ioreg_space_chk #(.DW(DW), .PORT_A(PORT_A)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .ds_rd    (ds_rd),
    .bit_op   (bit_op),
    .bit_cmd  (bit_cmd),
    .bit_sel  (bit_sel),
    .addr     (addr),
    .rdata    (rdata),
    .skip     (skip),
    .port_out (port_out),
    .dir_out  (dir_out),
    .latch_q  (latch_q)
);

// File: tb/sim_ioreg_space.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random operations,
// compared against a behavioural model kept in bench variables.
module sim_ioreg_space;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_rd = 1'b0, io_wr = 1'b0, ds_rd = 1'b0, bit_op = 1'b0;
    logic [1:0] bit_cmd = 2'b00;
    logic [2:0] bit_sel = 3'd0;
    logic [5:0] addr = 6'd0;
    logic [7:0] wdata = 8'h00, pin_in = 8'h00;
    logic [7:0] rdata, port_out, dir_out;
    logic       skip;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_port = 8'h00, m_dir = 8'h00, m_pin = 8'h00, m_latch = 8'h00;

    always #10 clk = ~clk;

    ioreg_space u0 (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .ds_rd(ds_rd),
        .bit_op(bit_op), .bit_cmd(bit_cmd), .bit_sel(bit_sel), .addr(addr),
        .wdata(wdata), .pin_in(pin_in), .rdata(rdata), .skip(skip),
        .port_out(port_out), .dir_out(dir_out)
    );

    function automatic bit f_rsv(input logic [5:0] a);
        return (a <= 6'h02) || (a >= 6'h0C && a <= 6'h14);
    endfunction

    function automatic logic [7:0] f_read(input logic [5:0] a);
        if (a == 6'h0B) return m_port;
        if (a == 6'h0A) return m_dir;
        if (a == 6'h09) return m_pin;
        if (f_rsv(a))   return m_latch;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        {io_rd, io_wr, ds_rd, bit_op} = 4'b0000;
    endtask

    task automatic op_rd(input logic [5:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        addr = a; io_rd = 1'b1;
        e = f_read(a);
        idle();
        m_latch = e;
        chk(req, rdata, e);
    endtask

    task automatic op_ds(input logic [5:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        addr = a; ds_rd = 1'b1;
        e = f_read(a);
        idle();
        chk(req, rdata, e);
    endtask

    task automatic op_wr(input logic [5:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        addr = a; wdata = d; io_wr = 1'b1;
        idle();
        if (a == 6'h0B) m_port = d;
        if (a == 6'h0A) m_dir  = d;
        chk({req, " port"}, port_out, m_port);
        chk({req, " dir"}, dir_out, m_dir);
    endtask

    task automatic op_bit(input logic [5:0] a, input logic [1:0] c, input logic [2:0] b,
                          input string req);
        logic [7:0] old, nv;
        logic       es;
        @(negedge clk);
        addr = a; bit_cmd = c; bit_sel = b; bit_op = 1'b1;
        old = f_read(a);
        nv  = old;
        es  = 1'b0;
        case (c)
            2'b00: nv = old | (8'h01 << b);
            2'b01: nv = old & ~(8'h01 << b);
            2'b10: es = old[b];
            default: es = ~old[b];
        endcase
        idle();
        m_latch = old;
        if (!c[1]) begin
            if (a == 6'h0B) m_port = nv;
            if (a == 6'h0A) m_dir  = nv;
        end
        chk({req, " port"}, port_out, m_port);
        chk({req, " dir"}, dir_out, m_dir);
        chk({req, " skip"}, {7'd0, skip}, {7'd0, es});
    endtask

    // Peek the latch through a data-space load of a reserved address
    task automatic peek(input string req);
        op_ds(6'h0C, req);
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
        m_pin = v;
    endtask

    // Watchdog: a hung run counts as one failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 port", port_out, 8'h00);
        chk("R1 dir", dir_out, 8'h00);
        chk("R1 skip", {7'd0, skip}, 8'h00);
        peek("R1 latch");

        // R8: set bit 2 on 0xF3
        op_wr(6'h0B, 8'hF3, "R6 port write");
        op_bit(6'h0B, 2'b00, 3'd2, "R8 set");
        chk("R8 port value", port_out, 8'hF7);
        peek("R8 latch holds pre-value");
        op_bit(6'h0B, 2'b01, 3'd7, "R8 clear");
        peek("R8 latch after clear");

        // R9: tests load full byte
        op_bit(6'h0B, 2'b10, 3'd0, "R9 skip-if-set");
        op_bit(6'h0B, 2'b11, 3'd3, "R9 skip-if-clear");
        peek("R9 latch after test");

        // R6/R7: pin write ignored, reserved writes ignored
        op_wr(6'h0A, 8'h5A, "R6 dir write");
        op_wr(6'h09, 8'hFF, "R6 pin write ignored");
        op_wr(6'h10, 8'h33, "R7 rsv write ignored");
        peek("R7 latch unchanged");

        // R11/R2: pin synchronization then read
        set_pins(8'hA5);
        op_rd(6'h09, "R11 pin read");
        op_rd(6'h14, "R3 rsv read");
        op_rd(6'h00, "R3 rsv read low");
        peek("R3 latch unchanged");

        // R5: data-space load leaves latch
        op_ds(6'h0A, "R5 ds dir");
        peek("R5 latch unchanged");

        // R12: unmapped reads 0x00 and loads 0x00
        op_rd(6'h20, "R12 unmapped");
        peek("R12 latch zero");

        // R10: bit ops on reserved address
        op_rd(6'h0B, "R2 port read");
        op_bit(6'h0D, 2'b00, 3'd0, "R10 rsv set");
        op_bit(6'h12, 2'b10, 3'd1, "R10 rsv test");
        peek("R10 latch kept");

        // R4: long idle
        repeat (50) idle();
        peek("R4 latch after idle");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [5:0] a;
            int k;
            k = $urandom % 4;
            case (k)
                0: a = 6'h0B;
                1: a = 6'h0A;
                2: a = 6'h09;
                default: a = 6'($urandom % 64);
            endcase
            case ($urandom % 7)
                0: op_rd(a, "R2 rand read");
                1: op_ds(a, "R5 rand ds");
                2: op_wr(a, 8'($urandom), "R6 rand write");
                3: op_bit(a, 2'($urandom), 3'($urandom), "R8 rand bit");
                4: peek("R4 rand peek");
                5: if (($urandom % 8) == 0) set_pins(8'($urandom)); else idle();
                default: op_rd(6'($urandom % 64), "R3 rand read");
            endcase
        end
        peek("R4 final latch");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule